// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns a single pulse-width input into the two gate commands of a synchronous buck half-bridge and keeps the two switches from conducting together. Neither switch is turned on on a timer alone. The high-side command waits until the digitised low-side gate feedback shows the low-side gate is discharged, and then waits a further programmable number of clock cycles. The low-side command waits until the digitised switch-node comparator reports the node is low, which shows the high-side switch has stopped conducting. Turn-off is never delayed.

A polarity strap selects whether a high pulse-width input means "high side on" or "high side off". A synchronous-mode select can hold the low side off so that the stage runs as a plain non-synchronous buck. An enable and a lockout input (undervoltage or over-temperature) force both commands low. If the feedback needed for a pending turn-on does not arrive within a programmable number of cycles, the block latches a fault and keeps both commands low until enable is dropped and raised again. Every asynchronous input is passed through a two-stage synchronizer before use, so a change on any input cannot reach an output before the third rising clock edge after it.

Top module: `deadtime_bridge_ctrl`

## Requirements
- R1: `hs_gate` may rise only when the synchronized `low_gate_fb` was low (low-side gate discharged) on the cycle the turn-on was decided; while `low_gate_fb` stays high `hs_gate` stays low.
- R2: `ls_gate` may rise only when the synchronized `node_low` was high and `sync_en` was high on the cycle the turn-on was decided; while `node_low` stays low `ls_gate` stays low.
- R3: With the high side already requested, `hs_gate` rises on exactly the (3 + `hs_extra_dly`)-th rising clock edge after `low_gate_fb` falls.
- R4: While enable is low, both gate commands are low within three clock edges, and the latched fault flag is cleared.
- R5: While `sync_en` is low, `ls_gate` stays low whatever `pwm_in` does, while the high side still follows the input.
- R6: With `pol_invert` = 0, `pwm_in` = 1 requests the high side and `pwm_in` = 0 the low side; with `pol_invert` = 1 the meanings are swapped.
- R7: While `lockout` is high, both gate commands are low within three clock edges; normal switching resumes after it is released.
- R8: When the low-side request is withdrawn, `ls_gate` falls within three clock edges without waiting for any feedback.
- R9: If the feedback a pending turn-on waits for stays absent for more than `fb_timeout` cycles, `fault` goes high, both commands stay low, and `fault` holds through any later request until enable goes low.
- R10: `hs_gate` and `ls_gate` are never high in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all delays count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Pulse-width command from the controller |
| enable | input | 1 | High to allow switching |
| sync_en | input | 1 | High for synchronous rectification, low holds the low side off |
| pol_invert | input | 1 | Polarity strap: 1 inverts the meaning of `pwm_in` |
| low_gate_fb | input | 1 | Digitised low-side gate level, 1 = gate still charged |
| node_low | input | 1 | Digitised switch-node comparator, 1 = node below threshold |
| lockout | input | 1 | Undervoltage or over-temperature shutdown request |
| hs_extra_dly | input | DLY_W | Extra high-side turn-on delay in cycles |
| fb_timeout | input | TMO_W | Cycles a pending turn-on may wait for feedback |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| fault | output | 1 | Latched feedback-timeout fault |

## Verification
The bench builds the block with its default widths (8-bit delay, 10-bit timeout) and drives `hs_extra_dly` = 4 and `fb_timeout` = 40, small enough that the extra-delay edge count and the timeout latch both fall within a short run while leaving room to show the delay is not zero. A plant model returns the gate and switch-node feedback two cycles after the commands move, and can be detached so that feedback is held stale on purpose; that brings the wait-for-feedback stalls, the non-waiting turn-off and the timeout fault within reach.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_FAULT   = 3'd5
  } bridge_st_t;

  // High side is wanted when the input, after the polarity strap, is high.
  function automatic logic hs_request(input logic pwm, input logic inv);
    return pwm ^ inv;
  endfunction

  // Low side is wanted in the other half of the period, synchronous mode only.
  function automatic logic ls_request(input logic pwm, input logic inv,
                                      input logic sync_mode);
    return sync_mode & ~(pwm ^ inv);
  endfunction

endpackage

// File: rtl/dtb_sync.sv
module dtb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/dtb_core.sv
module dtb_core
  import dtb_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_s,
  input  logic             en_s,
  input  logic             sync_s,
  input  logic             inv_s,
  input  logic             lgfb_s,
  input  logic             nlow_s,
  input  logic             lock_s,
  input  logic [DLY_W-1:0] extra_dly,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             hs_cmd,
  output logic             ls_cmd,
  output logic             fault_o
);

  bridge_st_t       st, st_nx;
  logic [DLY_W-1:0] dcnt, dcnt_nx;
  logic [TMO_W-1:0] tcnt, tcnt_nx;

  // Named internal events
  logic hs_want, ls_want, tmo_hit, dly_done;
  assign hs_want  = hs_request(pwm_s, inv_s);
  assign ls_want  = ls_request(pwm_s, inv_s, sync_s);
  assign tmo_hit  = (tcnt == tmo_limit);
  assign dly_done = (dcnt >= extra_dly);

  always_comb begin
    st_nx   = st;
    dcnt_nx = dcnt;
    tcnt_nx = tcnt;
    if (!en_s) begin
      st_nx   = ST_OFF;
      dcnt_nx = '0;
      tcnt_nx = '0;
    end else if (st == ST_FAULT) begin
      st_nx = ST_FAULT;
    end else if (lock_s) begin
      st_nx   = ST_OFF;
      dcnt_nx = '0;
      tcnt_nx = '0;
    end else begin
      case (st)
        ST_OFF: begin
          dcnt_nx = '0;
          tcnt_nx = '0;
          if (hs_want)      st_nx = ST_HS_WAIT;
          else if (ls_want) st_nx = ST_LS_WAIT;
        end
        ST_HS_WAIT: begin
          if (!hs_want) begin
            st_nx = ST_OFF;
          end else if (lgfb_s) begin
            dcnt_nx = '0;
            if (tmo_hit) st_nx = ST_FAULT;
            else         tcnt_nx = tcnt + 1'b1;
          end else if (dly_done) begin
            st_nx = ST_HS_ON;
          end else begin
            dcnt_nx = dcnt + 1'b1;
          end
        end
        ST_HS_ON: if (!hs_want) st_nx = ST_OFF;
        ST_LS_WAIT: begin
          if (!ls_want) begin
            st_nx = ST_OFF;
          end else if (!nlow_s) begin
            if (tmo_hit) st_nx = ST_FAULT;
            else         tcnt_nx = tcnt + 1'b1;
          end else begin
            st_nx = ST_LS_ON;
          end
        end
        ST_LS_ON: if (!ls_want) st_nx = ST_OFF;
        default:  st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      dcnt <= '0;
      tcnt <= '0;
    end else begin
      st   <= st_nx;
      dcnt <= dcnt_nx;
      tcnt <= tcnt_nx;
    end
  end

  assign hs_cmd  = (st == ST_HS_ON);
  assign ls_cmd  = (st == ST_LS_ON);
  assign fault_o = (st == ST_FAULT);

  // R1: high side turns on only after the low-side gate read discharged
  a_r1_hs_after_lgate_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_cmd) |-> !$past(lgfb_s));
  // R2: low side turns on only after the node read low, in synchronous mode
  a_r2_ls_after_node_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_cmd) |-> ($past(nlow_s) && $past(sync_s)));
  // R4: enable low drives both commands low
  a_r4_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs_cmd && !ls_cmd && !fault_o));
  // R5: non-synchronous mode keeps the low side off
  a_r5_nonsync_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_s |=> !ls_cmd);
  // R7: lockout forces both commands low
  a_r7_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> (!hs_cmd && !ls_cmd));
  // R9: a latched fault holds while enable stays high
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && en_s) |=> fault_o);
  // R9: while faulted, no gate command
  a_r9_fault_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!hs_cmd && !ls_cmd));

endmodule

// File: rtl/deadtime_bridge_ctrl.sv
module deadtime_bridge_ctrl #(
  parameter int DLY_W       = 8,
  parameter int TMO_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             enable,
  input  logic             sync_en,
  input  logic             pol_invert,
  input  logic             low_gate_fb,
  input  logic             node_low,
  input  logic             lockout,
  input  logic [DLY_W-1:0] hs_extra_dly,
  input  logic [TMO_W-1:0] fb_timeout,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic             fault
);

  localparam int NIN = 7;

  logic [NIN-1:0] raw_in, syn_in;

  assign raw_in = {pwm_in, enable, sync_en, pol_invert, low_gate_fb, node_low, lockout};

  dtb_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw_in),
    .q_sync (syn_in)
  );

  dtb_core #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_s    (syn_in[6]),
    .en_s     (syn_in[5]),
    .sync_s   (syn_in[4]),
    .inv_s    (syn_in[3]),
    .lgfb_s   (syn_in[2]),
    .nlow_s   (syn_in[1]),
    .lock_s   (syn_in[0]),
    .extra_dly(hs_extra_dly),
    .tmo_limit(fb_timeout),
    .hs_cmd   (hs_gate),
    .ls_cmd   (ls_gate),
    .fault_o  (fault)
  );

endmodule

// File: tb/deadtime_bridge_ctrl_tb.sv
module deadtime_bridge_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EXTRA      = 4;
  localparam int TMO        = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, enable = 1'b0, sync_en = 1'b1, pol_invert = 1'b0, lockout = 1'b0;
  logic plant_auto = 1'b1, lgfb_force = 1'b0, nlow_force = 1'b1;
  logic [1:0] lg_d, sw_d;
  logic low_gate_fb, node_low;
  logic [7:0] hs_extra_dly = 8'(EXTRA);
  logic [9:0] fb_timeout = 10'(TMO);
  logic hs_gate, ls_gate, fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit no_ls_window = 1'b0;
  int overlap_cycles = 0;
  int ls_in_window = 0;

  typedef struct {
    string      tag;
    logic [2:0] exp;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Plant: feedback follows the commands two cycles late
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_d <= 2'b00;
      sw_d <= 2'b11;
    end else begin
      lg_d <= {lg_d[0], ls_gate};
      sw_d <= {sw_d[0], ~hs_gate};
    end
  end
  assign low_gate_fb = plant_auto ? lg_d[1] : lgfb_force;
  assign node_low    = plant_auto ? sw_d[1] : nlow_force;

  deadtime_bridge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable), .sync_en(sync_en),
    .pol_invert(pol_invert), .low_gate_fb(low_gate_fb), .node_low(node_low),
    .lockout(lockout), .hs_extra_dly(hs_extra_dly), .fb_timeout(fb_timeout),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault(fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard
  task automatic expect_out(input string tag, input logic h, input logic l, input logic f);
    item_t it;
    @(negedge clk);
    it.tag = tag;
    it.exp = {h, l, f};
    sbq.push_back(it);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk({it.tag, " {hs,ls,fault}"}, int'({hs_gate, ls_gate, fault}), int'(it.exp));
      end
    end
  end

  // Per-cycle watchers (R10 and R5)
  always @(negedge clk) begin
    if (rst_n && hs_gate && ls_gate) begin
      overlap_cycles++;
      fails++;
      $display("FAIL R10 both gates high actual=1 expected=0");
    end
    if (no_ls_window && ls_gate) ls_in_window++;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    cycles(3);
    rst_n = 1'b1;
    expect_out("reset", 1'b0, 1'b0, 1'b0);

    // R6 / R2: non-inverted, pwm low requests the low side
    enable = 1'b1;
    cycles(12);
    expect_out("R6 pwm0 low side", 1'b0, 1'b1, 1'b0);
    pwm_in = 1'b1;
    cycles(20);
    expect_out("R6 pwm1 high side", 1'b1, 1'b0, 1'b0);
    pwm_in = 1'b0;
    cycles(20);
    expect_out("R6 back to low side", 1'b0, 1'b1, 1'b0);

    // R8 / R1 / R3 with detached plant, low-side gate still reading charged
    lgfb_force = 1'b1;
    nlow_force = 1'b1;
    plant_auto = 1'b0;
    pwm_in = 1'b1;
    cycles(3);
    chk("R8 ls_gate after request drop", int'(ls_gate), 0);
    cycles(10);
    chk("R1 hs_gate held while gate fb high", int'(hs_gate), 0);
    lgfb_force = 1'b0;
    n = 0;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk);
      #1;
      if (hs_gate) begin
        n = k;
        break;
      end
    end
    chk("R3 edges to hs_gate", n, 3 + EXTRA);

    // R2: low side waits for the node to read low
    @(negedge clk);
    nlow_force = 1'b0;
    pwm_in = 1'b0;
    cycles(12);
    chk("R2 ls_gate held while node high", int'(ls_gate), 0);
    chk("R2 hs_gate off", int'(hs_gate), 0);
    nlow_force = 1'b1;
    cycles(6);
    chk("R2 ls_gate after node low", int'(ls_gate), 1);
    plant_auto = 1'b1;
    cycles(6);

    // R5: non-synchronous mode
    sync_en = 1'b0;
    cycles(4);
    no_ls_window = 1'b1;
    for (int p = 0; p < 4; p++) begin
      pwm_in = 1'b1;
      cycles(15);
      pwm_in = 1'b0;
      cycles(15);
    end
    pwm_in = 1'b1;
    cycles(15);
    expect_out("R5 high side in non-sync", 1'b1, 1'b0, 1'b0);
    cycles(2);
    no_ls_window = 1'b0;
    chk("R5 ls_gate cycles high in non-sync", ls_in_window, 0);
    pwm_in = 1'b0;
    cycles(10);
    sync_en = 1'b1;
    cycles(15);

    // R6: inverted polarity
    pol_invert = 1'b1;
    pwm_in = 1'b1;
    cycles(20);
    expect_out("R6 inv pwm1 low side", 1'b0, 1'b1, 1'b0);
    pwm_in = 1'b0;
    cycles(20);
    expect_out("R6 inv pwm0 high side", 1'b1, 1'b0, 1'b0);

    // R7: lockout
    lockout = 1'b1;
    cycles(3);
    chk("R7 hs_gate under lockout", int'(hs_gate), 0);
    chk("R7 ls_gate under lockout", int'(ls_gate), 0);
    cycles(10);
    expect_out("R7 held off", 1'b0, 1'b0, 1'b0);
    lockout = 1'b0;
    cycles(20);
    expect_out("R7 resumes", 1'b1, 1'b0, 1'b0);

    // R4: enable low
    enable = 1'b0;
    cycles(3);
    chk("R4 hs_gate with enable low", int'(hs_gate), 0);
    chk("R4 ls_gate with enable low", int'(ls_gate), 0);
    pol_invert = 1'b0;
    cycles(10);

    // R9: timeout with gate feedback stuck high
    lgfb_force = 1'b1;
    plant_auto = 1'b0;
    pwm_in = 1'b1;
    enable = 1'b1;
    cycles(TMO - 10);
    chk("R9 fault before timeout", int'(fault), 0);
    cycles(20);
    expect_out("R9 fault latched", 1'b0, 1'b0, 1'b1);
    lgfb_force = 1'b0;
    pwm_in = 1'b0;
    cycles(20);
    expect_out("R9 fault holds through request", 1'b0, 1'b0, 1'b1);
    enable = 1'b0;
    plant_auto = 1'b1;
    cycles(6);
    expect_out("R4 fault cleared by enable low", 1'b0, 1'b0, 1'b0);
    enable = 1'b1;
    cycles(15);
    expect_out("R9 normal after re-enable", 1'b0, 1'b1, 1'b0);

    cycles(4);
    chk("R10 overlap cycles", overlap_cycles, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule